// File: doc/BRIEF.md
# Masked Receive-Address Filter for Multi-BSS Operation

This block decides whether a received frame's BSSID is one the interface should answer. Instead of an exact compare against the station MAC, it compares only the bit positions that a 48-bit mask selects. An address is accepted when it agrees with the MAC on every selected bit. The resulting accept flag feeds the acknowledgement logic, which sits outside this block.

A helper unit builds the mask from the set of hosted BSSIDs:
- A clear restores the mask to all ones.
- Each BSSID presented with a valid strobe then removes every bit where that BSSID differs from the MAC.

The helper shows its result as a 32-bit low word and a 16-bit high word. The host copies these into the active mask through two word-write ports.

With one BSS every mask bit stays set and the compare is exact. With several BSSes only the bits they all share with the MAC are checked. Some foreign addresses are therefore accepted by design.

Addresses are little-endian vectors: address byte 0, the first octet on the air, is bits [7:0].

Top module: `bssid_mask_filter`

## Requirements
- R1: After reset, and in the cycle after `bld_clr` is asserted, the built mask (`{bld_mask_hi, bld_mask_lo}`) is all ones.
- R2: Each cycle with `bld_vld` high and `bld_clr` low, the built mask becomes `mask & ~(mac_addr ^ bld_bssid)`, visible one cycle later. Mask bits never go from zero to one except through clear or reset.
- R3: When `bld_clr` and `bld_vld` are high in the same cycle, the clear wins and the BSSID is ignored.
- R4: After reset the active mask is all ones, so only a frame BSSID equal to `mac_addr` is accepted.
- R5: A low-word write replaces active mask bits [31:0] and leaves bits [47:32] unchanged. A high-word write replaces bits [47:32] and leaves bits [31:0] unchanged. Mask bit [7:0] covers address byte 0.
- R6: One cycle after `frm_vld`, `acc_vld` is high for one cycle. `acc_ok` is 1 exactly when `(frm_bssid & mask) == (mac_addr & mask)`. `acc_ok` is 0 whenever `acc_vld` is 0. Back-to-back frames each get a result.
- R7: A mask write in the same cycle as `frm_vld` does not affect that frame's decision. It applies from the next frame on.
- R8: With MAC ...0001 and hosted BSSIDs ...0100 and ...1001 in the low nibble (upper bits equal to the MAC), the built mask is all ones except low nibble 0010. Frames ending 0110 are then rejected, and frames ending 0001, 0100, 1001 and 0101 are accepted.
- R9: An address that is not hosted but matches the MAC on all masked bits, such as one ending 1101 in the R8 setup, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_addr | input | 48 | Station MAC address, byte 0 in bits [7:0] |
| bld_clr | input | 1 | Restore built mask to all ones |
| bld_vld | input | 1 | Fold `bld_bssid` into the built mask |
| bld_bssid | input | 48 | Hosted BSSID to fold |
| bld_mask_lo | output | 32 | Built mask bits [31:0] |
| bld_mask_hi | output | 16 | Built mask bits [47:32] |
| msk_lo_we | input | 1 | Write low word of active mask |
| msk_lo_data | input | 32 | Low word data |
| msk_hi_we | input | 1 | Write high word of active mask |
| msk_hi_data | input | 16 | High word data |
| frm_vld | input | 1 | Frame BSSID valid strobe |
| frm_bssid | input | 48 | BSSID of the received frame |
| acc_vld | output | 1 | Decision valid, one cycle after `frm_vld` |
| acc_ok | output | 1 | Frame accepted for acknowledgement |

## Verification
The bench rebuilds the two-BSSID example and checks that the built mask is exactly all ones except low nibble 0010. A builder that ORed instead of ANDed, or that skipped the inversion, would give a different word.

It presents a clear together with a valid BSSID. A design that let the fold win would leave mask bits cleared.

It writes one mask word at a time with a byte-0-only pattern. A decoder that crossed words or reversed byte order would then accept or reject the wrong frames.

It changes the mask in the same cycle as a frame strobe. A comparison that used the new mask would flip that frame's decision. Back-to-back strobes catch a result flag that stretched over several cycles or dropped a frame.

// File: rtl/bssf_pkg.sv
package bssf_pkg;
  localparam int BYTE_W = 8;

  // fold one hosted BSSID into the running mask
  function automatic logic [BYTE_W-1:0] fold_lane(input logic [BYTE_W-1:0] cur,
                                                  input logic [BYTE_W-1:0] mac,
                                                  input logic [BYTE_W-1:0] bss);
    return cur & ~(mac ^ bss);
  endfunction
endpackage

// File: rtl/bssf_mask_builder.sv
module bssf_mask_builder
  import bssf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mac_addr,
  input  logic              clr,
  input  logic              vld,
  input  logic [ADDR_W-1:0] bssid,
  output logic [ADDR_W-1:0] mask
);
  logic [ADDR_W-1:0] mask_q;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr)
        mask_q[b*BYTE_W +: BYTE_W] <= '1;
      else if (vld)
        mask_q[b*BYTE_W +: BYTE_W] <= fold_lane(mask_q[b*BYTE_W +: BYTE_W],
                                                mac_addr[b*BYTE_W +: BYTE_W],
                                                bssid[b*BYTE_W +: BYTE_W]);
    end
  end

  assign mask = mask_q;

  // clear (also when paired with a valid BSSID) restores all ones
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mask_q == '1));
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (clr && vld) |=> (mask_q == '1));
  // folding only ever removes bits
  assert_no_set_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> ((mask_q & ~$past(mask_q)) == '0));
endmodule

// File: rtl/bssf_mask_regs.sv
module bssf_mask_regs
  import bssf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int LO_BYTES   = 4,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W,
  localparam int LO_W   = LO_BYTES * BYTE_W,
  localparam int HI_W   = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic [LO_W-1:0]   lo_data,
  input  logic              hi_we,
  input  logic [HI_W-1:0]   hi_data,
  output logic [ADDR_W-1:0] mask
);
  logic [ADDR_W-1:0] mask_q;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    if (b < LO_BYTES) begin : g_lo
      always_ff @(posedge clk) begin
        if (rst)        mask_q[b*BYTE_W +: BYTE_W] <= '1;
        else if (lo_we) mask_q[b*BYTE_W +: BYTE_W] <= lo_data[b*BYTE_W +: BYTE_W];
      end
    end else begin : g_hi
      always_ff @(posedge clk) begin
        if (rst)        mask_q[b*BYTE_W +: BYTE_W] <= '1;
        else if (hi_we) mask_q[b*BYTE_W +: BYTE_W] <= hi_data[(b-LO_BYTES)*BYTE_W +: BYTE_W];
      end
    end
  end

  assign mask = mask_q;

  assert_lo_keeps_hi_R5: assert property (@(posedge clk) disable iff (rst)
    (lo_we && !hi_we) |=> $stable(mask_q[ADDR_W-1:LO_W]));
  assert_hi_keeps_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (hi_we && !lo_we) |=> $stable(mask_q[LO_W-1:0]));
endmodule

// File: rtl/bssf_compare.sv
module bssf_compare
  import bssf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mac_addr,
  input  logic [ADDR_W-1:0] mask,
  input  logic              frm_vld,
  input  logic [ADDR_W-1:0] frm_bssid,
  output logic              acc_vld,
  output logic              acc_ok
);
  logic [ADDR_BYTES-1:0] lane_eq;
  logic                  vld_q, ok_q;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_lane
    assign lane_eq[b] = ((frm_bssid[b*BYTE_W +: BYTE_W] ^ mac_addr[b*BYTE_W +: BYTE_W])
                         & mask[b*BYTE_W +: BYTE_W]) == '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      vld_q <= frm_vld;
      ok_q  <= frm_vld && (&lane_eq);
    end
  end

  assign acc_vld = vld_q;
  assign acc_ok  = ok_q;

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    frm_vld |=> acc_vld);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    !frm_vld |=> !acc_vld);
  assert_ok_qualified_R6: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |-> !acc_ok);
endmodule

// File: rtl/bssid_mask_filter.sv
module bssid_mask_filter
  import bssf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int LO_BYTES   = 4,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W,
  localparam int LO_W   = LO_BYTES * BYTE_W,
  localparam int HI_W   = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mac_addr,
  input  logic              bld_clr,
  input  logic              bld_vld,
  input  logic [ADDR_W-1:0] bld_bssid,
  output logic [LO_W-1:0]   bld_mask_lo,
  output logic [HI_W-1:0]   bld_mask_hi,
  input  logic              msk_lo_we,
  input  logic [LO_W-1:0]   msk_lo_data,
  input  logic              msk_hi_we,
  input  logic [HI_W-1:0]   msk_hi_data,
  input  logic              frm_vld,
  input  logic [ADDR_W-1:0] frm_bssid,
  output logic              acc_vld,
  output logic              acc_ok
);
  logic [ADDR_W-1:0] built_mask;
  logic [ADDR_W-1:0] active_mask;

  bssf_mask_builder #(.ADDR_BYTES(ADDR_BYTES)) u_builder (
    .clk(clk), .rst(rst), .mac_addr(mac_addr),
    .clr(bld_clr), .vld(bld_vld), .bssid(bld_bssid), .mask(built_mask)
  );

  assign bld_mask_lo = built_mask[LO_W-1:0];
  assign bld_mask_hi = built_mask[ADDR_W-1:LO_W];

  bssf_mask_regs #(.ADDR_BYTES(ADDR_BYTES), .LO_BYTES(LO_BYTES)) u_regs (
    .clk(clk), .rst(rst),
    .lo_we(msk_lo_we), .lo_data(msk_lo_data),
    .hi_we(msk_hi_we), .hi_data(msk_hi_data),
    .mask(active_mask)
  );

  bssf_compare #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
    .clk(clk), .rst(rst), .mac_addr(mac_addr), .mask(active_mask),
    .frm_vld(frm_vld), .frm_bssid(frm_bssid),
    .acc_vld(acc_vld), .acc_ok(acc_ok)
  );
endmodule

// File: tb/bssid_mask_filter_tb_top.sv
`timescale 1ns/1ps
module bssid_mask_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [47:0] mac_addr;
  logic        bld_clr, bld_vld;
  logic [47:0] bld_bssid;
  logic [31:0] bld_mask_lo;
  logic [15:0] bld_mask_hi;
  logic        msk_lo_we, msk_hi_we;
  logic [31:0] msk_lo_data;
  logic [15:0] msk_hi_data;
  logic        frm_vld;
  logic [47:0] frm_bssid;
  logic        acc_vld, acc_ok;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  bssid_mask_filter dut_i (.*);

  // {expected accept, frame BSSID} with the R8 mask loaded
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 48'h0000_0000_0006},   // R8 foreign, rejected
    {1'b1, 48'h0000_0000_0001},   // R8 MAC itself
    {1'b1, 48'h0000_0000_0004},   // R8 hosted
    {1'b1, 48'h0000_0000_0009},   // R8 hosted
    {1'b1, 48'h0000_0000_000D},   // R9 false accept
    {1'b1, 48'h0000_0000_0005},   // R8
    {1'b0, 48'h0000_0100_0001},   // R8 upper bit differs
    {1'b0, 48'h0000_0000_0003}    // R8 checked bit differs
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] f, input logic exp_ok, input string req);
    @(negedge clk);
    frm_vld = 1'b1; frm_bssid = f;
    @(negedge clk);
    frm_vld = 1'b0;
    check({req, " vld"}, {47'd0, acc_vld}, 48'd1);
    check({req, " ok"},  {47'd0, acc_ok},  {47'd0, exp_ok});
  endtask

  task automatic wr_mask(input logic [31:0] lo, input logic wlo,
                         input logic [15:0] hi, input logic whi);
    @(negedge clk);
    msk_lo_we = wlo; msk_lo_data = lo; msk_hi_we = whi; msk_hi_data = hi;
    @(negedge clk);
    msk_lo_we = 1'b0; msk_hi_we = 1'b0;
  endtask

  task automatic fold(input logic [47:0] b, input logic c);
    @(negedge clk);
    bld_vld = 1'b1; bld_bssid = b; bld_clr = c;
    @(negedge clk);
    bld_vld = 1'b0; bld_clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mac_addr = 48'h0000_0000_0001;
    bld_clr = 0; bld_vld = 0; bld_bssid = '0;
    msk_lo_we = 0; msk_hi_we = 0; msk_lo_data = '0; msk_hi_data = '0;
    frm_vld = 0; frm_bssid = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R1 reset built mask", {bld_mask_hi, bld_mask_lo}, {48{1'b1}});
    check("R6 reset acc_vld", {47'd0, acc_vld}, 48'd0);
    send(48'h0000_0000_0001, 1'b1, "R4 exact match");
    send(48'h8000_0000_0001, 1'b0, "R4 bit47 differs");
    send(48'h0000_0000_0005, 1'b0, "R4 bit2 differs");

    // build mask from two hosted BSSIDs
    fold(48'h0000_0000_0004, 1'b0);
    check("R2 first fold", {bld_mask_hi, bld_mask_lo}, 48'hFFFF_FFFF_FFFA);
    fold(48'h0000_0000_0009, 1'b0);
    check("R8 built mask", {bld_mask_hi, bld_mask_lo}, 48'hFFFF_FFFF_FFF2);
    wr_mask(bld_mask_lo, 1'b1, bld_mask_hi, 1'b1);
    for (int i = 0; i < 8; i++)
      send(VEC[i][47:0], VEC[i][48], "R8 R9 table");

    // back-to-back frames
    @(negedge clk);
    frm_vld = 1'b1; frm_bssid = 48'h0000_0000_0006;
    @(negedge clk);
    frm_bssid = 48'h0000_0000_0004;
    check("R6 b2b first vld", {47'd0, acc_vld}, 48'd1);
    check("R6 b2b first ok", {47'd0, acc_ok}, 48'd0);
    @(negedge clk);
    frm_vld = 1'b0;
    check("R6 b2b second vld", {47'd0, acc_vld}, 48'd1);
    check("R6 b2b second ok", {47'd0, acc_ok}, 48'd1);
    @(negedge clk);
    check("R6 pulse ends", {46'd0, acc_vld, acc_ok}, 48'd0);

    // clear beats valid
    fold(48'h0000_0000_00F0, 1'b1);
    check("R3 clear wins", {bld_mask_hi, bld_mask_lo}, {48{1'b1}});

    // word writes: low word only byte 0 checked, high still ones
    wr_mask(32'h0000_00FF, 1'b1, 16'h0000, 1'b0);
    send(48'h0000_1234_5601, 1'b1, "R5 lo bytes1-3 ignored");
    send(48'h0000_0000_0002, 1'b0, "R5 byte0 checked");
    send(48'h0100_0000_0001, 1'b0, "R5 hi kept");
    wr_mask(32'hFFFF_FFFF, 1'b0, 16'h0000, 1'b1);
    send(48'h0100_0000_0001, 1'b1, "R5 hi cleared");
    send(48'h0000_0000_0002, 1'b0, "R5 lo kept");

    // mask change in same cycle as frame
    wr_mask(32'hFFFF_FFFF, 1'b1, 16'hFFFF, 1'b1);
    @(negedge clk);
    frm_vld = 1'b1; frm_bssid = 48'h0000_0000_0002;
    msk_lo_we = 1'b1; msk_lo_data = 32'h0;
    @(negedge clk);
    frm_vld = 1'b0; msk_lo_we = 1'b0;
    check("R7 old mask used", {46'd0, acc_vld, acc_ok}, 48'd2);
    send(48'h0000_0000_0002, 1'b1, "R7 new mask next frame");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule